// File: doc/BRIEF.md
# Four-Channel Transfer Request Priority Arbiter

This block picks one of four transfer channels when more than one of them asks for the bus at the same time. Each channel drives one request bit. A two-bit mode field and four per-channel rotation bits choose the policy. There are two fixed orderings, a rotation over every channel, and a rotation that moves only the channels whose rotation bit is set. The winner gets a registered one-hot grant and a channel index.

The grant is held until the transfer engine pulses `xfer_done`. The rotation state moves forward on that pulse. After a transfer the block spends one idle cycle, then arbitrates again. The configuration inputs are sampled only when an arbitration happens. At that arbitration, any change in the mode or in the rotation bits puts the rotation back to its start order.

Top module: `dma_prio_arb`

## Requirements
- R1: While `rst` is high and after it is released with no request, `grant` is all-zero.
- R2: A request seen in an idle cycle gives a grant in the next cycle. `grant` has exactly bit n set, and `grant_idx` equals n, where n is the winner.
- R3: `grant` is always one-hot or zero. A new grant goes only to a channel whose request bit was high in the arbitration cycle.
- R4: Mode `00` uses the fixed order 0 > 1 > 2 > 3, so the lowest-numbered requester wins.
- R5: Mode `01` uses the fixed order 0 > 2 > 3 > 1.
- R6: In mode `11`, when channel c completes a transfer the new order is c+1, c+2, c+3, c (mod 4).
- R7: In mode `10`, a channel whose bit in `rr_en` is clear keeps rank equal to its index. When a channel with its bit set completes, it moves to the last rank among the set channels. The other set channels each move up one such rank. Bit i of `rr_en` belongs to channel i. Serving a channel whose bit is clear does not change the order.
- R8: While a grant is active and `xfer_done` is low, `grant` and `grant_idx` do not change, whatever happens on `req`, `prio_mode` or `rr_en`.
- R9: `xfer_done` during a grant clears `grant` in the next cycle, and that cycle gives no new grant. `xfer_done` while idle has no effect.
- R10: A change of `prio_mode` or `rr_en` takes effect only at the next arbitration. If the configuration at an arbitration differs from the one latched at the previous arbitration, the rotating order goes back to 0, 1, 2, 3.
- R11: After reset, the rotating order is 0, 1, 2, 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 4 | Transfer request, one bit per channel |
| prio_mode | input | 2 | 00 fixed A, 01 fixed B, 10 selective rotation, 11 full rotation |
| rr_en | input | 4 | Per-channel rotation enable for mode 10 |
| xfer_done | input | 1 | One-cycle pulse that ends the granted transfer |
| grant | output | 4 | One-hot grant, zero when idle |
| grant_idx | output | 2 | Index of the granted channel |

## Verification
The bench drives request patterns in which the two fixed orders disagree (requests from 1 and 2 together, or from 1 and 3 together). A design with the wrong order table grants the wrong channel there. In full rotation it serves channels out of index order. This catches a rotation that moves by one slot instead of jumping to the channel after the one served. Selective rotation is run with channels 1 and 3 rotating and channel 2 fixed; an update that moves fixed channels or skips slots then grants the wrong one. The bench also changes requests and configuration in the middle of a transfer, pulses done while idle, and goes between modes and back again. This exposes re-arbitration during a transfer, grants issued in the cycle after done, and rotation state that survives a mode change.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  // Channel count must stay a power of two: rotation wraps by truncation.
  localparam int CH_N = 4;
  localparam int CH_W = $clog2(CH_N);

  typedef logic [CH_N-1:0][CH_W-1:0] order_t;

  typedef enum logic [1:0] {
    PM_FIX_A  = 2'b00,
    PM_FIX_B  = 2'b01,
    PM_RR_SEL = 2'b10,
    PM_RR_ALL = 2'b11
  } pmode_e;

  // Index order 0,1,2,3: fixed order A and rotation start order.
  function automatic order_t seq_order();
    order_t o;
    for (int p = 0; p < CH_N; p++) o[p] = CH_W'(p);
    return o;
  endfunction

  // Fixed order B: 0, then 2..N-1, with 1 last.
  function automatic order_t alt_order();
    order_t o;
    o[0] = '0;
    for (int p = 1; p < CH_N - 1; p++) o[p] = CH_W'(p + 1);
    o[CH_N-1] = CH_W'(1);
    return o;
  endfunction
endpackage

// File: rtl/dma_arb_pick.sv
module dma_arb_pick
  import dma_arb_pkg::*;
#(
  parameter int N = CH_N,
  parameter int W = CH_W
) (
  input  order_t         order,
  input  logic [N-1:0]   req,
  output logic           hit,
  output logic [W-1:0]   win
);
  // Scan from lowest rank upward so the highest-ranked requester is kept last.
  always_comb begin
    hit = 1'b0;
    win = '0;
    for (int p = N - 1; p >= 0; p--) begin
      if (req[order[p]]) begin
        hit = 1'b1;
        win = order[p];
      end
    end
  end
endmodule

// File: rtl/dma_arb_order.sv
module dma_arb_order
  import dma_arb_pkg::*;
#(
  parameter int N = CH_N,
  parameter int W = CH_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_base,
  input  logic         adv,
  input  pmode_e       mode,
  input  logic [N-1:0] rr_mask,
  input  logic [W-1:0] served,
  output order_t       order_q
);
  order_t rot_next;
  order_t sel_next;

  // Full rotation: the channel after the served one takes the top rank.
  always_comb begin
    for (int p = 0; p < N; p++) rot_next[p] = served + W'(p + 1);
  end

  // Selective rotation: the served channel goes to the last rotating slot,
  // and the later rotating channels move up one rotating slot each.
  always_comb begin
    logic [W-1:0] pos;
    logic [W-1:0] pend;
    sel_next = order_q;
    pos = '0;
    for (int p = 0; p < N; p++)
      if (order_q[p] == served) pos = W'(p);
    pend = pos;
    for (int p = 0; p < N; p++) begin
      if (p > int'(pos) && rr_mask[order_q[p]]) begin
        sel_next[pend] = order_q[p];
        pend = W'(p);
      end
    end
    sel_next[pend] = served;
  end

  always_ff @(posedge clk) begin
    if (rst || load_base) begin
      order_q <= seq_order();
    end else if (adv) begin
      if (mode == PM_RR_ALL)
        order_q <= rot_next;
      else if (mode == PM_RR_SEL && rr_mask[served])
        order_q <= sel_next;
    end
  end
endmodule

// File: rtl/dma_prio_arb.sv
module dma_prio_arb
  import dma_arb_pkg::*;
#(
  parameter int N = CH_N,
  parameter int W = CH_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] req,
  input  logic [1:0]   prio_mode,
  input  logic [N-1:0] rr_en,
  input  logic         xfer_done,
  output logic [N-1:0] grant,
  output logic [W-1:0] grant_idx
);
  logic         busy_q;
  logic [N-1:0] grant_q;
  logic [W-1:0] idx_q;
  pmode_e       mode_q;
  logic [N-1:0] rr_q;
  order_t       order_q;
  order_t       eff_order;
  pmode_e       mode_in;
  logic         cfg_chg;
  logic         hit;
  logic [W-1:0] win;
  logic         arb_fire;
  logic         done_ok;

  assign mode_in  = pmode_e'(prio_mode);
  assign cfg_chg  = (mode_in != mode_q) || (rr_en != rr_q);
  assign arb_fire = !busy_q && hit;
  assign done_ok  = busy_q && xfer_done;

  always_comb begin
    case (mode_in)
      PM_FIX_A: eff_order = seq_order();
      PM_FIX_B: eff_order = alt_order();
      default:  eff_order = cfg_chg ? seq_order() : order_q;
    endcase
  end

  dma_arb_pick #(.N(N), .W(W)) u_pick (
    .order (eff_order),
    .req   (req),
    .hit   (hit),
    .win   (win)
  );

  dma_arb_order #(.N(N), .W(W)) u_order (
    .clk       (clk),
    .rst       (rst),
    .load_base (arb_fire && cfg_chg),
    .adv       (done_ok),
    .mode      (mode_q),
    .rr_mask   (rr_q),
    .served    (idx_q),
    .order_q   (order_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      grant_q <= '0;
      idx_q   <= '0;
      mode_q  <= PM_FIX_A;
      rr_q    <= '0;
    end else if (arb_fire) begin
      busy_q  <= 1'b1;
      grant_q <= {{(N-1){1'b0}}, 1'b1} << win;
      idx_q   <= win;
      mode_q  <= mode_in;
      rr_q    <= rr_en;
    end else if (done_ok) begin
      busy_q  <= 1'b0;
      grant_q <= '0;
    end
  end

  assign grant     = grant_q;
  assign grant_idx = idx_q;
endmodule

// File: rtl/dma_arb_chk.sv
module dma_arb_chk #(
  parameter int N = 4,
  parameter int W = 2
) (
  input logic         clk,
  input logic         rst,
  input logic [N-1:0] req,
  input logic [1:0]   prio_mode,
  input logic         xfer_done,
  input logic [N-1:0] grant,
  input logic [W-1:0] grant_idx
);
  assert_onehot_grant_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));

  assert_grant_to_requester_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(|grant) |-> ((grant & ~$past(req)) == '0));

  assert_idx_matches_R2: assert property (@(posedge clk) disable iff (rst)
    (|grant) |-> (grant[grant_idx] == 1'b1));

  assert_hold_until_done_R8: assert property (@(posedge clk) disable iff (rst)
    ((|grant) && !xfer_done) |=> (grant == $past(grant) && grant_idx == $past(grant_idx)));

  assert_release_on_done_R9: assert property (@(posedge clk) disable iff (rst)
    ((|grant) && xfer_done) |=> (grant == '0));

  assert_fixed_a_lowest_R4: assert property (@(posedge clk) disable iff (rst)
    ($rose(|grant) && $past(prio_mode) == 2'b00)
      |-> (grant == ($past(req) & (~$past(req) + {{(N-1){1'b0}}, 1'b1}))));
endmodule

bind dma_prio_arb dma_arb_chk #(.N(N), .W(W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req       (req),
  .prio_mode (prio_mode),
  .xfer_done (xfer_done),
  .grant     (grant),
  .grant_idx (grant_idx)
);

// File: tb/dma_prio_arb_tb.sv
module dma_prio_arb_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst;
  logic [3:0] req;
  logic [1:0] prio_mode;
  logic [3:0] rr_en;
  logic       xfer_done;
  logic [3:0] grant;
  logic [1:0] grant_idx;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // reference model state
  int  m_ord[4];
  bit  m_busy;
  int  m_g;
  int  m_mode;
  int  m_rr;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_prio_arb u_dut (
    .clk(clk), .rst(rst), .req(req), .prio_mode(prio_mode), .rr_en(rr_en),
    .xfer_done(xfer_done), .grant(grant), .grant_idx(grant_idx)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int k = 0; k < 4; k++) m_ord[k] = k;
    m_busy = 0; m_g = 0; m_mode = 0; m_rr = 0;
  endtask

  task automatic model_edge(input int r, input int m, input int e, input bit d);
    int eo[4];
    int q[$];
    if (!m_busy) begin
      if (r != 0) begin
        if (m != m_mode || e != m_rr)
          for (int k = 0; k < 4; k++) m_ord[k] = k;
        m_mode = m; m_rr = e;
        if (m == 0) eo = '{0, 1, 2, 3};
        else if (m == 1) eo = '{0, 2, 3, 1};
        else eo = m_ord;
        for (int k = 3; k >= 0; k--) if (r[eo[k]]) m_g = eo[k];
        m_busy = 1;
      end
    end else if (d) begin
      m_busy = 0;
      if (m_mode == 3) begin
        for (int k = 0; k < 4; k++) m_ord[k] = (m_g + 1 + k) % 4;
      end else if (m_mode == 2 && m_rr[m_g]) begin
        foreach (m_ord[k]) if (m_rr[m_ord[k]] && m_ord[k] != m_g) q.push_back(m_ord[k]);
        q.push_back(m_g);
        foreach (m_ord[k]) if (m_rr[m_ord[k]]) m_ord[k] = q.pop_front();
      end
    end
  endtask

  task automatic compare(input string tag);
    int eg;
    eg = m_busy ? (1 << m_g) : 0;
    check(grant == 4'(eg), {tag, " grant"}, grant, eg);
    if (m_busy) check(grant_idx == 2'(m_g), {tag, " grant_idx"}, grant_idx, m_g);
  endtask

  task automatic step(input logic [3:0] r, input logic [1:0] m, input logic [3:0] e,
                      input logic d, input string tag);
    req = r; prio_mode = m; rr_en = e; xfer_done = d;
    @(posedge clk);
    model_edge(r, m, e, d);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic expect_ch(input int ch, input string tag);
    int eg;
    eg = (ch < 0) ? 0 : (1 << ch);
    check(grant == 4'(eg), {tag, " directed grant"}, grant, eg);
  endtask

  task automatic serve(input logic [3:0] r, input logic [1:0] m, input logic [3:0] e,
                       input int exp, input string tag);
    step(r, m, e, 1'b0, tag);
    expect_ch(exp, tag);
    step(r, m, e, 1'b1, tag);
    expect_ch(-1, tag);
  endtask

  initial begin
    rst = 1'b1; req = '0; prio_mode = '0; rr_en = '0; xfer_done = 1'b0;
    model_reset();
    repeat (2) @(posedge clk);
    @(negedge clk);
    expect_ch(-1, "R1 in reset");
    rst = 1'b0;
    step(4'b0000, 2'b00, 4'b0000, 1'b0, "R1");
    expect_ch(-1, "R1 idle");

    serve(4'b0100, 2'b00, 4'b0000, 2, "R2");
    serve(4'b1111, 2'b00, 4'b0000, 0, "R4");
    serve(4'b1110, 2'b00, 4'b0000, 1, "R4");
    serve(4'b1100, 2'b00, 4'b0000, 2, "R4");

    serve(4'b1110, 2'b01, 4'b0000, 2, "R5");
    serve(4'b1010, 2'b01, 4'b0000, 3, "R5");
    serve(4'b0010, 2'b01, 4'b0000, 1, "R5");

    serve(4'b1111, 2'b11, 4'b0000, 0, "R11");
    serve(4'b1111, 2'b11, 4'b0000, 1, "R6");
    serve(4'b1111, 2'b11, 4'b0000, 2, "R6");
    serve(4'b1001, 2'b11, 4'b0000, 3, "R6");
    serve(4'b1010, 2'b11, 4'b0000, 1, "R6");
    serve(4'b1011, 2'b11, 4'b0000, 3, "R6");

    step(4'b0000, 2'b11, 4'b0000, 1'b1, "R9");
    expect_ch(-1, "R9 idle done");
    step(4'b0000, 2'b11, 4'b0000, 1'b0, "R9");
    expect_ch(-1, "R9 after idle done");
    step(4'b0000, 2'b11, 4'b0000, 1'b0, "R3");
    expect_ch(-1, "R3 no request");

    serve(4'b1110, 2'b10, 4'b1010, 1, "R7");
    serve(4'b1110, 2'b10, 4'b1010, 3, "R7");
    serve(4'b1110, 2'b10, 4'b1010, 1, "R7");
    serve(4'b0110, 2'b10, 4'b1010, 2, "R7");
    serve(4'b1110, 2'b10, 4'b1010, 3, "R7");
    serve(4'b1011, 2'b10, 4'b1010, 0, "R7");

    step(4'b0011, 2'b00, 4'b0000, 1'b0, "R8");
    expect_ch(0, "R8 start");
    for (int k = 0; k < 3; k++) begin
      step(4'b1100, 2'b11, 4'b1111, 1'b0, "R8");
      expect_ch(0, "R8 held");
    end
    step(4'b1100, 2'b11, 4'b1111, 1'b1, "R9");
    expect_ch(-1, "R9 gap");
    serve(4'b1110, 2'b11, 4'b1111, 1, "R10");

    serve(4'b1111, 2'b11, 4'b0000, 0, "R10");
    serve(4'b1111, 2'b11, 4'b0000, 1, "R10");
    serve(4'b1111, 2'b00, 4'b0000, 0, "R10");
    serve(4'b1111, 2'b11, 4'b0000, 0, "R10 rotation reset");

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule